// File: doc/BRIEF.md
# AUX Reply Timeout Encoder

This block converts a requested reply timeout, given in microseconds, into the two fields that a receive timer consumes: a 2-bit time-base code and a 7-bit length. The time base grows in power-of-two steps (8, 16, 32 and 64 us), and the block picks the finest one whose range covers the request. The length is the request divided by that unit, rounded up, and then clamped to the largest value the field can hold. A request of zero restores the default setting.

Each accepted request updates both fields in the same clock edge. At that edge the block also reports the timeout the fields held before the update, rebuilt from the old length and time-base code. It also reports a polling period equal to the request times a fixed multiplier. All division is done with shifts and remainder tests, with no general divider.

A controller issues a request on a valid/ready handshake. Ready is always high, so every request is taken on the edge where valid is high. One cycle later the new fields, the previous timeout and the polling period are visible on registered outputs, with a one-cycle done pulse.

Top module: `aux_tmo_encoder`

## Requirements
- R1: After reset, len_q is 69, mult_q is 0, prev_q is 0, poll_q is 0 and done_q is 0.
- R2: A request of 0 sets mult_q to 0 and len_q to 69.
- R3: A nonzero request T selects mult_q 0 when T <= 1016, 1 when T <= 2032, 2 when T <= 4064, and 3 otherwise. The time unit for code m is 8 << m microseconds.
- R4: len_q is T shifted right by (3 + mult_q), plus one when any of the shifted-out bits is nonzero.
- R5: len_q never exceeds 127. A rounded length above 127 is written as 127.
- R6: On the done cycle, prev_q equals the len_q value before the update multiplied by 8 << (the mult_q value before the update).
- R7: On the done cycle, poll_q equals the request times POLL_MULT (default 10), truncated to the width of poll_q.
- R8: req_ready is always 1. done_q is 1 exactly in the cycle after an accepted request. len_q and mult_q change only on an accepted request, and both change in the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted (always 1) |
| req_us | input | 32 | Requested timeout in microseconds |
| len_q | output | 7 | Timeout length field |
| mult_q | output | 2 | Time-base code |
| prev_q | output | 13 | Timeout held before the last update, in microseconds |
| poll_q | output | 36 | Polling period of the last request |
| done_q | output | 1 | One-cycle pulse after an accepted request |

## Verification
The hardest cases to reach are the exact band edges, where a one-microsecond step changes both the time-base code and the rounding. One such case is 8128 us, which just fits length 127 at the coarsest unit, while 8129 us must clamp to 127. The bench drives every band edge and its neighbour directly. It then runs a seeded random mix that is weighted toward the thresholds, toward small values and toward full 32-bit values. Because each request is checked for the previous timeout as well, the bench also confirms that the read-back uses the old fields across changes of time-base code.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;
    localparam int REQ_W      = 32;
    localparam int LEN_W      = 7;
    localparam int MULT_W     = 2;
    localparam int NUM_BANDS  = 4;
    localparam int BASE_SHIFT = 3;
    localparam int STEP_US    = 1016;
    localparam int DEF_LEN    = 69;
    localparam int DEF_MULT   = 0;
    localparam int LEN_MAX    = 127;
    localparam int PREV_W     = LEN_W + BASE_SHIFT + NUM_BANDS - 1;
endpackage

// File: rtl/aux_tmo_band.sv
module aux_tmo_band
    import aux_tmo_pkg::*;
(
    input  logic [REQ_W-1:0]  req_us,
    output logic [MULT_W-1:0] band
);
    logic [NUM_BANDS-2:0] above;

    genvar k;
    generate
        for (k = 0; k < NUM_BANDS - 1; k++) begin : g_thr
            localparam logic [REQ_W-1:0] THR = REQ_W'(STEP_US) << k;
            assign above[k] = (req_us > THR);
        end
    endgenerate

    // thermometer code to count
    always_comb begin
        band = '0;
        for (int i = 0; i < NUM_BANDS - 1; i++) begin
            if (above[i]) band = band + MULT_W'(1);
        end
    end
endmodule

// File: rtl/aux_tmo_len.sv
module aux_tmo_len
    import aux_tmo_pkg::*;
(
    input  logic [REQ_W-1:0]  req_us,
    input  logic [MULT_W-1:0] band,
    output logic [LEN_W-1:0]  len
);
    logic [REQ_W-1:0] cand [NUM_BANDS];

    genvar b;
    generate
        for (b = 0; b < NUM_BANDS; b++) begin : g_unit
            localparam int SH = BASE_SHIFT + b;
            localparam logic [REQ_W-1:0] RMASK = (REQ_W'(1) << SH) - REQ_W'(1);
            logic [REQ_W-1:0] quo;
            logic             rem_nz;
            assign quo     = req_us >> SH;
            assign rem_nz  = |(req_us & RMASK);
            assign cand[b] = quo + REQ_W'(rem_nz);
        end
    endgenerate

    logic [REQ_W-1:0] sel;

    always_comb begin
        sel = cand[NUM_BANDS-1];
        for (int i = 0; i < NUM_BANDS; i++) begin
            if (band == MULT_W'(i)) sel = cand[i];
        end
        if (sel > REQ_W'(LEN_MAX)) len = LEN_W'(LEN_MAX);
        else                       len = sel[LEN_W-1:0];
    end
endmodule

// File: rtl/aux_tmo_prev.sv
module aux_tmo_prev
    import aux_tmo_pkg::*;
(
    input  logic [LEN_W-1:0]  old_len,
    input  logic [MULT_W-1:0] old_mult,
    output logic [PREV_W-1:0] prev_us
);
    localparam logic [PREV_W-1:0] FALLBACK = PREV_W'(DEF_LEN) << BASE_SHIFT;

    always_comb begin
        prev_us = FALLBACK;
        for (int i = 0; i < (1 << MULT_W); i++) begin
            if (old_mult == MULT_W'(i)) begin
                if (i < NUM_BANDS) prev_us = PREV_W'(old_len) << (BASE_SHIFT + i);
                else               prev_us = FALLBACK;
            end
        end
    end
endmodule

// File: rtl/aux_tmo_encoder.sv
module aux_tmo_encoder
    import aux_tmo_pkg::*;
#(
    parameter int POLL_MULT   = 10,
    localparam int POLL_MUL_W = $clog2(POLL_MULT + 1),
    localparam int POLL_W     = REQ_W + POLL_MUL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_us,
    output logic [LEN_W-1:0]  len_q,
    output logic [MULT_W-1:0] mult_q,
    output logic [PREV_W-1:0] prev_q,
    output logic [POLL_W-1:0] poll_q,
    output logic              done_q
);
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [MULT_W-1:0] mult;
        logic [PREV_W-1:0] prev;
        logic [POLL_W-1:0] poll;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic [MULT_W-1:0] band_w;
    logic [LEN_W-1:0]  len_w;
    logic [PREV_W-1:0] prev_w;
    logic              take;

    assign req_ready = 1'b1;
    assign take      = req_valid && req_ready;

    aux_tmo_band u_band (.req_us(req_us), .band(band_w));
    aux_tmo_len  u_len  (.req_us(req_us), .band(band_w), .len(len_w));
    aux_tmo_prev u_prev (.old_len(st_q.len), .old_mult(st_q.mult), .prev_us(prev_w));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (take) begin
            st_d.done = 1'b1;
            st_d.prev = prev_w;
            st_d.poll = POLL_W'(req_us) * POLL_W'(POLL_MULT);
            if (req_us == '0) begin
                st_d.len  = LEN_W'(DEF_LEN);
                st_d.mult = MULT_W'(DEF_MULT);
            end else begin
                st_d.len  = len_w;
                st_d.mult = band_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.len  <= LEN_W'(DEF_LEN);
            st_q.mult <= MULT_W'(DEF_MULT);
            st_q.prev <= '0;
            st_q.poll <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_q  = st_q.len;
    assign mult_q = st_q.mult;
    assign prev_q = st_q.prev;
    assign poll_q = st_q.poll;
    assign done_q = st_q.done;

    // R5 length field stays within its clamp
    a_r5_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_W'(LEN_MAX));

    // R8 done pulse follows an accepted request by one cycle
    a_r8_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> done_q);
    a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !done_q);
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(len_q) && $stable(mult_q)));
    a_r8_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready);

    // R2 zero request restores defaults
    a_r2_zero_default: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_us == '0) |=> (len_q == LEN_W'(DEF_LEN) && mult_q == MULT_W'(DEF_MULT)));

    // R3 smallest band for short requests, largest for long ones
    a_r3_fine_band: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_us != '0 && req_us <= REQ_W'(STEP_US)) |=> (mult_q == '0));
    a_r3_coarse_band: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_us > (REQ_W'(STEP_US) << (NUM_BANDS - 2))) |=> (mult_q == MULT_W'(NUM_BANDS - 1)));

    // R6 previous timeout rebuilt from the fields before the update
    a_r6_prev_readback: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (prev_q == (PREV_W'($past(len_q)) << (BASE_SHIFT + int'($past(mult_q))))));
endmodule

// File: tb/aux_tmo_encoder_tb.sv
module aux_tmo_encoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_MULT  = 10;
    localparam int POLL_W     = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_us = '0;
    logic [6:0]  len_q;
    logic [1:0]  mult_q;
    logic [12:0] prev_q;
    logic [35:0] poll_q;
    logic        done_q;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [6:0] m_len  = 7'd69;
    logic [1:0] m_mult = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_tmo_encoder #(.POLL_MULT(POLL_MULT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_us(req_us), .len_q(len_q), .mult_q(mult_q), .prev_q(prev_q),
        .poll_q(poll_q), .done_q(done_q)
    );

    function automatic logic [1:0] f_mult(input logic [31:0] t);
        if (t == 0)         return 2'd0;
        if (t <= 32'd1016)  return 2'd0;
        if (t <= 32'd2032)  return 2'd1;
        if (t <= 32'd4064)  return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [6:0] f_len(input logic [31:0] t);
        longint unsigned unit, q;
        if (t == 0) return 7'd69;
        unit = 64'd8 << f_mult(t);
        q = (longint'(t) + unit - 1) / unit;
        if (q > 127) q = 127;
        return q[6:0];
    endfunction

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] t);
        logic [12:0] e_prev;
        logic [35:0] e_poll;
        @(negedge clk);
        req_valid = 1'b1;
        req_us    = t;
        e_prev = 13'(m_len) << (3 + m_mult);
        e_poll = 36'(64'(t) * POLL_MULT);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 done", done_q, 1);
        chk("R2/R3 mult", mult_q, f_mult(t));
        chk("R4/R5 len", len_q, f_len(t));
        chk("R6 prev", prev_q, e_prev);
        chk("R7 poll", poll_q, e_poll);
        m_len  = f_len(t);
        m_mult = f_mult(t);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R8 idle done", done_q, 0);
        chk("R8 idle len", len_q, m_len);
        chk("R8 idle mult", mult_q, m_mult);
    endtask

    initial begin
        logic [31:0] t;
        int unsigned r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 len", len_q, 69);
        chk("R1 mult", mult_q, 0);
        chk("R1 prev", prev_q, 0);
        chk("R1 poll", poll_q, 0);
        chk("R1 done", done_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ready", req_ready, 1);
        // directed corners: R2 zero, R3 band edges, R4 rounding, R5 clamp
        do_req(32'd1);
        do_req(32'd8);
        do_req(32'd9);
        do_req(32'd1016);
        do_req(32'd1017);
        idle_check();
        do_req(32'd2032);
        do_req(32'd2033);
        do_req(32'd4064);
        do_req(32'd4065);
        do_req(32'd8128);
        do_req(32'd8129);
        do_req(32'd0);
        do_req(32'hFFFF_FFFF);
        idle_check();
        do_req(32'd0);
        for (int i = 0; i < 300; i++) begin
            r = $urandom % 4;
            case (r)
                0: t = $urandom % 24;
                1: t = (32'd1016 << ($urandom % 3)) + 32'($urandom % 5) - 32'd2;
                2: t = $urandom % 10000;
                default: t = $urandom;
            endcase
            do_req(t);
            if ($urandom % 8 == 0) idle_check();
        end
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule